// File: doc/BRIEF.md
# Backlog-Balanced Cell Buffer Dispatcher

This block sits between a packet segmenter, a set of independent narrow cell memories and a traffic manager. Cells arrive already segmented; a packet that is one byte longer than a cell already takes two cells. When the first cell of a packet arrives, the block picks the memory that has the fewest outstanding read requests. Every cell of that packet is then written to the chosen memory. For each cell written, the block reports the chosen memory index, so that the external queue lists can record where the cell is stored. If the chosen memory reports that it is full, the whole packet is discarded and a drop counter advances.

The traffic manager issues reads in an order the block cannot predict. The only lever on load balance is therefore where writes are placed. Each read request names a memory and an address. The block forwards it to that memory with a sequence tag, taken modulo the resequencer depth. The memories return data with their own latencies. A resequencer stores each return under its tag and emits data strictly in request order.

The write path is a three-state machine. `ST_IDLE` waits for a start-of-packet cell. From `ST_IDLE`, a start cell whose selected memory is not full writes that cell and moves to `ST_PASS`, or stays in `ST_IDLE` if the cell is also the end of the packet. A start cell whose selected memory is full is discarded and moves to `ST_DROP`, or stays in `ST_IDLE` if it is also the end of the packet. `ST_PASS` writes each cell to the locked memory and returns to `ST_IDLE` on the end cell. `ST_DROP` discards cells and returns to `ST_IDLE` on the end cell.

Top module: `pb_dispatch`

## Requirements
- R1: On a start-of-packet cell, the block selects the memory whose backlog count is smallest; if several counts are equal, the lowest index wins. With no reads outstanding, memory 0 is chosen.
- R2: For every cell of an accepted packet, `wr_en` is one-hot on the selected memory, `wr_buf_id` gives that memory's index, and `wr_data` equals `in_data`, all in the same cycle. All cells of the packet go to the same memory.
- R3: When the selected memory's `buf_full` bit is high on the start cell, no cell of that packet raises any `wr_en` bit, and `drop_count` rises by exactly one after the start cell. A full bit on a memory that is not selected has no effect.
- R4: A memory's backlog count increases by one when a read is forwarded to it and decreases by one when read data returns from it. A packet placed after the returns therefore reflects the reduced backlog.
- R5: An accepted read raises `fw_valid` only on bit `rq_buf` in the same cycle, with `fw_addr` equal to `rq_addr`. `fw_tag` counts 0, 1, 2 and so on, modulo DEPTH (default 8), one step per accepted read.
- R6: `rq_ready` is low while DEPTH reads are outstanding, and then no read is forwarded.
- R7: Returned data appears on `out_data`, with `out_valid` high, in request order whatever order the returns arrive in. Data is released one cell per cycle, and only once the oldest outstanding tag has returned.
- R8: After reset, `rq_ready` is 1, `out_valid` is 0, `wr_en` is 0 and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Incoming cell valid |
| in_sop | input | 1 | Cell starts a packet |
| in_eop | input | 1 | Cell ends a packet |
| in_data | input | CELL_W | Cell payload |
| buf_full | input | NBUF | Per-memory full flag |
| wr_en | output | NBUF | Per-memory cell write strobe |
| wr_data | output | CELL_W | Cell payload to memories |
| wr_buf_id | output | $clog2(NBUF) | Memory index holding this cell |
| drop_count | output | DROP_W | Dropped packet count |
| rq_valid | input | 1 | Read request from the traffic manager |
| rq_buf | input | $clog2(NBUF) | Memory addressed by the read |
| rq_addr | input | ADDR_W | Cell address within that memory |
| rq_ready | output | 1 | Read request accepted |
| fw_valid | output | NBUF | Per-memory forwarded read strobe |
| fw_addr | output | ADDR_W | Forwarded cell address |
| fw_tag | output | $clog2(DEPTH) | Sequence tag of the forwarded read |
| rt_valid | input | NBUF | Per-memory read return valid |
| rt_tag | input | NBUF*$clog2(DEPTH) | Returned tags, one slice per memory |
| rt_data | input | NBUF*CELL_W | Returned data, one slice per memory |
| out_valid | output | 1 | Ordered read data valid |
| out_data | output | CELL_W | Ordered read data |

## Verification
The hardest conditions to reach are a full resequencer whose oldest entry arrives last, and tied backlog counts at the moment a packet starts. Both depend on the timing of returns, which the bench fully controls. The bench issues DEPTH reads without answering any of them, checks the stall, and then returns them in reverse order, so the whole window drains in a single burst. It reaches the tie cases by issuing chosen unanswered reads to chosen memories before starting packets, so that the backlog counts are known exactly.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } wst_t;
endpackage

// File: rtl/pb_least_sel.sv
module pb_least_sel #(
    parameter int NBUF = 4,
    parameter int BL_W = 4,
    localparam int ID_W = $clog2(NBUF)
) (
    input  logic [NBUF*BL_W-1:0] counts,
    output logic [ID_W-1:0]      sel_id
);
    logic [BL_W-1:0] best;

    always_comb begin
        best   = counts[BL_W-1:0];
        sel_id = '0;
        for (int i = 1; i < NBUF; i++) begin
            if (counts[i*BL_W +: BL_W] < best) begin
                best   = counts[i*BL_W +: BL_W];
                sel_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/pb_backlog_bank.sv
module pb_backlog_bank #(
    parameter int NBUF = 4,
    parameter int BL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBUF-1:0]      inc,
    input  logic [NBUF-1:0]      dec,
    output logic [NBUF*BL_W-1:0] counts
);
    for (genvar g = 0; g < NBUF; g++) begin : g_cnt
        logic [BL_W-1:0] c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c <= '0;
            end else if (inc[g] && !dec[g]) begin
                c <= c + 1'b1;
            end else if (dec[g] && !inc[g]) begin
                c <= c - 1'b1;
            end
        end
        assign counts[g*BL_W +: BL_W] = c;
    end
endmodule

// File: rtl/pb_reseq.sv
module pb_reseq #(
    parameter int NBUF   = 4,
    parameter int DEPTH  = 8,
    parameter int CELL_W = 16,
    localparam int SEQ_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    output logic [SEQ_W-1:0]       next_tag,
    output logic                   has_room,
    input  logic [NBUF-1:0]        rt_valid,
    input  logic [NBUF*SEQ_W-1:0]  rt_tag,
    input  logic [NBUF*CELL_W-1:0] rt_data,
    output logic                   out_valid,
    output logic [CELL_W-1:0]      out_data
);
    logic [DEPTH-1:0]  slot_vld;
    logic [CELL_W-1:0] slot_dat [DEPTH];
    logic [SEQ_W-1:0]  head;
    logic [SEQ_W-1:0]  tail;
    logic [CNT_W-1:0]  used;
    logic              rel;

    assign rel      = slot_vld[head];
    assign has_room = (used != CNT_W'(DEPTH));
    assign next_tag = tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            head      <= '0;
            tail      <= '0;
            used      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rel;
            if (rel) begin
                out_data       <= slot_dat[head];
                slot_vld[head] <= 1'b0;
                head           <= head + 1'b1;
            end
            for (int i = 0; i < NBUF; i++) begin
                if (rt_valid[i]) begin
                    slot_vld[rt_tag[i*SEQ_W +: SEQ_W]] <= 1'b1;
                end
            end
            if (alloc) begin
                tail <= tail + 1'b1;
            end
            used <= used + CNT_W'(alloc) - CNT_W'(rel);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBUF; i++) begin
            if (rt_valid[i]) begin
                slot_dat[rt_tag[i*SEQ_W +: SEQ_W]] <= rt_data[i*CELL_W +: CELL_W];
            end
        end
    end
endmodule

// File: rtl/pb_dispatch.sv
module pb_dispatch
    import pb_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int CELL_W = 16,
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 8,
    parameter int DROP_W = 16,
    localparam int ID_W  = $clog2(NBUF),
    localparam int SEQ_W = $clog2(DEPTH),
    localparam int BL_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic                   in_eop,
    input  logic [CELL_W-1:0]      in_data,
    input  logic [NBUF-1:0]        buf_full,
    output logic [NBUF-1:0]        wr_en,
    output logic [CELL_W-1:0]      wr_data,
    output logic [ID_W-1:0]        wr_buf_id,
    output logic [DROP_W-1:0]      drop_count,
    input  logic                   rq_valid,
    input  logic [ID_W-1:0]        rq_buf,
    input  logic [ADDR_W-1:0]      rq_addr,
    output logic                   rq_ready,
    output logic [NBUF-1:0]        fw_valid,
    output logic [ADDR_W-1:0]      fw_addr,
    output logic [SEQ_W-1:0]       fw_tag,
    input  logic [NBUF-1:0]        rt_valid,
    input  logic [NBUF*SEQ_W-1:0]  rt_tag,
    input  logic [NBUF*CELL_W-1:0] rt_data,
    output logic                   out_valid,
    output logic [CELL_W-1:0]      out_data
);
    wst_t                  state, state_nx;
    logic [ID_W-1:0]       lock_id;
    logic [ID_W-1:0]       least_id;
    logic [ID_W-1:0]       cur_id;
    logic                  cell_go;
    logic                  drop_now;
    logic                  rq_take;
    logic [NBUF*BL_W-1:0]  backlog;

    pb_least_sel #(.NBUF(NBUF), .BL_W(BL_W)) u_sel (
        .counts (backlog),
        .sel_id (least_id)
    );

    pb_backlog_bank #(.NBUF(NBUF), .BL_W(BL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (fw_valid),
        .dec    (rt_valid),
        .counts (backlog)
    );

    pb_reseq #(.NBUF(NBUF), .DEPTH(DEPTH), .CELL_W(CELL_W)) u_rsq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (rq_take),
        .next_tag  (fw_tag),
        .has_room  (rq_ready),
        .rt_valid  (rt_valid),
        .rt_tag    (rt_tag),
        .rt_data   (rt_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lock_id    <= '0;
            drop_count <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cell_go) begin
                lock_id <= cur_id;
            end
            if (drop_now) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

    // Next state and write decisions
    always_comb begin
        state_nx = state;
        cell_go  = 1'b0;
        drop_now = 1'b0;
        cur_id   = lock_id;
        unique case (state)
            ST_IDLE: begin
                cur_id = least_id;
                if (in_valid && in_sop) begin
                    if (buf_full[least_id]) begin
                        drop_now = 1'b1;
                        state_nx = in_eop ? ST_IDLE : ST_DROP;
                    end else begin
                        cell_go  = 1'b1;
                        state_nx = in_eop ? ST_IDLE : ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                if (in_valid) begin
                    cell_go = 1'b1;
                    if (in_eop) state_nx = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (in_valid && in_eop) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    assign wr_data   = in_data;
    assign wr_buf_id = cur_id;
    assign rq_take   = rq_valid && rq_ready;
    assign fw_addr   = rq_addr;

    for (genvar g = 0; g < NBUF; g++) begin : g_strobe
        assign wr_en[g]    = cell_go && (cur_id == ID_W'(g));
        assign fw_valid[g] = rq_take && (rq_buf == ID_W'(g));
    end
endmodule

// File: rtl/pb_dispatch_chk.sv
module pb_dispatch_chk #(
    parameter int NBUF   = 4,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_eop,
    input logic [NBUF-1:0]   wr_en,
    input logic [DROP_W-1:0] drop_count,
    input logic              rq_valid,
    input logic              rq_ready,
    input logic [NBUF-1:0]   fw_valid
);
    p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_same_buf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_en) && !in_eop) |=> (wr_en == '0 || wr_en == $past(wr_en)));

    p_drop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));

    p_drop_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count) || $past(wr_en) == '0));

    p_fw_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fw_valid));

    p_fw_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fw_valid) |-> rq_valid);

    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_ready |-> (fw_valid == '0));
endmodule

bind pb_dispatch pb_dispatch_chk #(.NBUF(NBUF), .DROP_W(DROP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_eop     (in_eop),
    .wr_en      (wr_en),
    .drop_count (drop_count),
    .rq_valid   (rq_valid),
    .rq_ready   (rq_ready),
    .fw_valid   (fw_valid)
);

// File: tb/test_pb_dispatch.sv
module test_pb_dispatch;
    localparam int NBUF = 4, CW = 16, AW = 10, DEPTH = 8, DW = 16;
    localparam int IDW = 2, SW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [CW-1:0] in_data = '0;
    logic [NBUF-1:0] buf_full = '0;
    logic [NBUF-1:0] wr_en;
    logic [CW-1:0] wr_data;
    logic [IDW-1:0] wr_buf_id;
    logic [DW-1:0] drop_count;
    logic rq_valid = 0;
    logic [IDW-1:0] rq_buf = '0;
    logic [AW-1:0] rq_addr = '0;
    logic rq_ready;
    logic [NBUF-1:0] fw_valid;
    logic [AW-1:0] fw_addr;
    logic [SW-1:0] fw_tag;
    logic [NBUF-1:0] rt_valid = '0;
    logic [NBUF*SW-1:0] rt_tag = '0;
    logic [NBUF*CW-1:0] rt_data = '0;
    logic out_valid;
    logic [CW-1:0] out_data;

    int n_run = 0, n_fail = 0;
    int nseq = 0;
    logic [CW-1:0] tag_data [DEPTH];
    logic [CW-1:0] expq [$];

    always #2 clk = ~clk;

    pb_dispatch i_pb_dispatch (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pkt(input int ncell, input int exp_buf, input bit exp_drop, input string req);
        for (int c = 0; c < ncell; c++) begin
            @(negedge clk);
            in_valid = 1; in_sop = (c == 0); in_eop = (c == ncell - 1);
            in_data = CW'(16'h5000 + c + 16 * exp_buf);
            #1;
            if (exp_drop) chk(req, 32'(wr_en), 0);
            else begin
                chk(req, 32'(wr_en), 32'(1 << exp_buf));
                chk({req, " id"}, 32'(wr_buf_id), 32'(exp_buf));
                chk({req, " data"}, 32'(wr_data), 32'(in_data));
            end
            @(posedge clk); #0.5;
            in_valid = 0; in_sop = 0; in_eop = 0;
        end
    endtask

    task automatic rd(input int b, input int addr);
        @(negedge clk);
        rq_valid = 1; rq_buf = IDW'(b); rq_addr = AW'(addr);
        tag_data[nseq % DEPTH] = CW'(16'hA000 + nseq);
        #1;
        chk("R5 fwd", 32'(fw_valid), 32'(1 << b));
        chk("R5 addr", 32'(fw_addr), 32'(addr));
        chk("R5 tag", 32'(fw_tag), 32'(nseq % DEPTH));
        expq.push_back(tag_data[nseq % DEPTH]);
        nseq++;
        @(posedge clk); #0.5;
        rq_valid = 0;
    endtask

    task automatic ret(input int b, input int tag);
        rt_valid[b] = 1'b1;
        rt_tag[b*SW +: SW] = SW'(tag);
        rt_data[b*CW +: CW] = tag_data[tag];
    endtask

    task automatic ret_go();
        @(posedge clk); #0.5;
        rt_valid = '0;
    endtask

    // Monitor: ordered output (R7)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) chk("R7 unexpected output", 32'(out_data), 0);
            else chk("R7 order", 32'(out_data), 32'(expq.pop_front()));
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1;
        @(negedge clk);
        // R8
        chk("R8 ready", 32'(rq_ready), 1);
        chk("R8 out_valid", 32'(out_valid), 0);
        chk("R8 wr_en", 32'(wr_en), 0);
        chk("R8 drops", 32'(drop_count), 0);

        // R1 R2: all idle -> memory 0
        pkt(3, 0, 0, "R1 R2 idle pick");
        // R4: backlog 2,1,0,0 -> memory 2
        rd(0, 5); rd(0, 6); rd(1, 7);
        pkt(2, 2, 0, "R4 least backlog");
        // R1 tie: backlog 2,1,1,1 -> memory 1
        rd(2, 8); rd(3, 9);
        pkt(1, 1, 0, "R1 tie lowest index");
        // R7: out-of-order returns from memory 0
        @(negedge clk); ret(0, 1); ret_go();
        @(negedge clk); ret(0, 0); ret_go();
        // R4: memory 0 backlog back to 0 -> chosen
        pkt(1, 0, 0, "R4 after returns");
        // several returns in one cycle
        @(negedge clk); ret(3, 4); ret(1, 2); ret_go();
        @(negedge clk); ret(2, 3); ret_go();
        repeat (4) @(negedge clk);
        chk("R7 drained", 32'(expq.size()), 0);

        // R3: drop
        buf_full = 4'b0001;
        pkt(3, 0, 1, "R3 drop multi");
        @(negedge clk);
        chk("R3 count", 32'(drop_count), 1);
        buf_full = 4'b0010;
        pkt(2, 0, 0, "R3 other full ignored");
        chk("R3 count kept", 32'(drop_count), 1);
        buf_full = 4'b0001;
        pkt(1, 0, 1, "R3 drop single");
        @(negedge clk);
        chk("R3 count single", 32'(drop_count), 2);
        buf_full = '0;

        // R6: fill the resequencer
        for (int k = 0; k < DEPTH; k++) rd(k % NBUF, 32 + k);
        @(negedge clk);
        chk("R6 stall", 32'(rq_ready), 0);
        rq_valid = 1; rq_buf = 2;
        #1 chk("R6 no forward", 32'(fw_valid), 0);
        @(posedge clk); #0.5 rq_valid = 0;
        // reverse returns, oldest last
        for (int k = DEPTH - 1; k >= 0; k--) begin
            @(negedge clk);
            ret(k % NBUF, (nseq - DEPTH + k) % DEPTH);
            ret_go();
        end
        repeat (DEPTH + 4) @(negedge clk);
        chk("R7 burst drained", 32'(expq.size()), 0);
        chk("R6 ready again", 32'(rq_ready), 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule